// File: doc/BRIEF.md
# Block-Selected Register RAM Controller

This block is a 56-bit data register memory with a 10-bit register address space. The memory is not addressed directly on each access. Instead, a select strobe latches a register address. Later accesses then work relative to that latch. An exact access reads or writes the latched register itself. An indexed access reaches any of the 16 registers in the same aligned 16-register block, picked by a 4-bit index.

The address space is sparse. A fixed decoder, steered by configuration inputs, decides which addresses are populated:
- whether the extended-functions memory is present,
- how many 64-register memory modules are fitted (0 to 4),
- whether each of the two extended-memory ports is enabled.

Some addresses are never populated. Selecting one of them leaves every RAM block inactive, and this is how software releases the RAM before talking to a peripheral. A peripheral strobe takes the low 8 bits of the same select value. If it arrives while RAM is still active, it raises a sticky conflict flag.

Top module: `regblk_ram`

## Requirements
- R1: On a clock edge with `sel_stb` high, the 10-bit `sel_value` is latched as the selected register. Accesses in that same cycle still use the previous selection.
- R2: An access with `acc_en` high and `acc_indexed` low works on the exact latched register.
  - A write (`acc_we`=1) stores `acc_wdata`.
  - A read (`acc_we`=0) presents the word on `rd_data` after the next clock edge.
  - `rd_data` holds that word until the next read.
- R3: An access with `acc_indexed` high works on the register whose upper 6 address bits come from the latched address and whose low 4 bits are `acc_idx`.
- R4: Addresses 000-00F and 0C0-0FF are always populated. Addresses 010-03F, 200, 2F0-2FF, 300 and 3F0-3FF are never populated.
- R5: Addresses 040-0BF are populated only while `cfg_xfunc` is 1.
- R6: Addresses 100-1FF form four 64-register groups, the lowest group first. Group g (0 to 3) is populated when g < `cfg_mod_count`. Counts above 4 act as 4.
- R7: Addresses 201-2EF are populated only while `cfg_xmem_lo` is 1. Addresses 301-3EF are populated only while `cfg_xmem_hi` is 1.
- R8: `ram_active` becomes 1 after a select edge exactly when the latched address is populated under the configuration at that edge. It then holds until the next select. Selecting 010, or anything in 3F0-3FF, drives it to 0.
- R9: While `ram_active` is 0, reads return all zeros and writes change no register.
- R10: An indexed access to an unpopulated register inside the active block behaves the same way: it reads as zero and the write is dropped.
- R11: A `per_stb` edge latches `sel_value[7:0]` onto `per_addr`. It sets `conflict` if RAM is active. When `sel_stb` comes in the same cycle, the new selection decides. `conflict` stays at 1 until reset.
- R12: A synchronous reset (`rst`=1) leaves the block in this state:
  - RAM deselected, as though 010 had been selected;
  - `conflict` at 0, `per_addr` at 0, `rd_data` at 0;
  - stored register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_stb | input | 1 | Latch `sel_value` as the selected register |
| per_stb | input | 1 | Latch low byte of `sel_value` as peripheral address |
| sel_value | input | 10 | Register / peripheral select value |
| cfg_xfunc | input | 1 | Extended-functions memory fitted (040-0BF) |
| cfg_mod_count | input | 3 | Number of 64-register modules in 100-1FF |
| cfg_xmem_lo | input | 1 | Extended memory at 201-2EF enabled |
| cfg_xmem_hi | input | 1 | Extended memory at 301-3EF enabled |
| acc_en | input | 1 | Perform a register access this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_indexed | input | 1 | 1 = block-indexed access, 0 = exact access |
| acc_idx | input | 4 | Register index within the active block |
| acc_wdata | input | 56 | Write data |
| rd_data | output | 56 | Read data, one cycle after a read |
| ram_active | output | 1 | A populated register is selected |
| per_addr | output | 8 | Latched peripheral address |
| conflict | output | 1 | Sticky: peripheral selected while RAM active |

## Verification
Directed selects sweep the edges of every map region under fixed configurations, so that an off-by-one in a region bound shows up as a wrong `ram_active`.

Writes followed by exact and indexed reads of distinct values in one block tell a wrong index splice apart from a wrong latch. Writes made while deselected, or to the hole at 200, are read back through a later valid selection. This shows that they were dropped rather than stored.

Random stimulus mixes selections, configuration changes, peripheral strobes (alone and combined with a select), and accesses in both modes. A model tracks the memory, the selection and the sticky flag.

// File: rtl/regblk_pkg.sv
package regblk_pkg;

  localparam int unsigned REG_AW   = 10;
  localparam int unsigned BLK_W    = 4;
  localparam int unsigned GRP_W    = 6;
  localparam int unsigned MOD_MAX  = 4;
  localparam logic [REG_AW-1:0] DESEL_ADDR = 10'h010;

  typedef struct packed {
    logic       xfunc;
    logic [2:0] mod_count;
    logic       xmem_lo;
    logic       xmem_hi;
  } map_cfg_t;

  // Fixed sparse map of populated register addresses.
  function automatic logic reg_populated(input logic [REG_AW-1:0] a, input map_cfg_t c);
    logic [2:0] mods;
    mods = (c.mod_count > 3'(MOD_MAX)) ? 3'(MOD_MAX) : c.mod_count;
    if (a <= 10'h00F)       return 1'b1;
    else if (a <= 10'h03F)  return 1'b0;
    else if (a <= 10'h0BF)  return c.xfunc;
    else if (a <= 10'h0FF)  return 1'b1;
    else if (a <= 10'h1FF)  return {1'b0, a[GRP_W+1:GRP_W]} < mods;
    else if (a == 10'h200)  return 1'b0;
    else if (a <= 10'h2EF)  return c.xmem_lo;
    else if (a <= 10'h300)  return 1'b0;
    else if (a <= 10'h3EF)  return c.xmem_hi;
    else                    return 1'b0;
  endfunction

endpackage

// File: rtl/regblk_decode.sv
module regblk_decode
  import regblk_pkg::*;
(
  input  logic [REG_AW-1:0] addr,
  input  map_cfg_t          cfg,
  output logic              populated
);
  always_comb populated = reg_populated(addr, cfg);
endmodule

// File: rtl/regblk_select.sv
module regblk_select
  import regblk_pkg::*;
#(
  parameter int AW = REG_AW,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_stb,
  input  logic          per_stb,
  input  logic [AW-1:0] sel_value,
  input  logic          sel_pop,
  output logic [AW-1:0] sel_q,
  output logic          active_q,
  output logic [PW-1:0] per_q,
  output logic          conflict_q
);
  // RAM state as seen by a peripheral strobe: a select in the same cycle wins.
  logic active_view;
  assign active_view = sel_stb ? sel_pop : active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= AW'(DESEL_ADDR);
      active_q   <= 1'b0;
      per_q      <= '0;
      conflict_q <= 1'b0;
    end else begin
      if (sel_stb) begin
        sel_q    <= sel_value;
        active_q <= sel_pop;
      end
      if (per_stb) begin
        per_q <= sel_value[PW-1:0];
        if (active_view) conflict_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/regblk_store.sv
module regblk_store #(
  parameter int DW = 56,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          rd_ok,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q;
  logic          ok_q;

  // Plain synchronous port, no reset on the array or its output register.
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_data;
    if (rd_en) q <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst)        ok_q <= 1'b0;
    else if (rd_en) ok_q <= rd_ok;
  end

  assign rd_data = ok_q ? q : '0;
endmodule

// File: rtl/regblk_ram.sv
module regblk_ram
  import regblk_pkg::*;
#(
  parameter int DATA_W = 56,
  parameter int PER_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_stb,
  input  logic              per_stb,
  input  logic [REG_AW-1:0] sel_value,
  input  logic              cfg_xfunc,
  input  logic [2:0]        cfg_mod_count,
  input  logic              cfg_xmem_lo,
  input  logic              cfg_xmem_hi,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic              acc_indexed,
  input  logic [BLK_W-1:0]  acc_idx,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              ram_active,
  output logic [PER_W-1:0]  per_addr,
  output logic              conflict
);
  localparam int N_DEC = 2;

  map_cfg_t                     cfg;
  logic [REG_AW-1:0]            sel_q;
  logic [REG_AW-1:0]            acc_addr;
  logic [N_DEC-1:0][REG_AW-1:0] dec_addr;
  logic [N_DEC-1:0]             dec_pop;
  logic                         acc_ok;

  assign cfg = '{xfunc: cfg_xfunc, mod_count: cfg_mod_count,
                 xmem_lo: cfg_xmem_lo, xmem_hi: cfg_xmem_hi};

  // Exact access uses the latch; indexed access splices the index into its block.
  assign acc_addr = acc_indexed ? {sel_q[REG_AW-1:BLK_W], acc_idx} : sel_q;

  // Decoder 0 judges the incoming select value, decoder 1 the access target.
  assign dec_addr[0] = sel_value;
  assign dec_addr[1] = acc_addr;

  for (genvar g = 0; g < N_DEC; g++) begin : g_dec
    regblk_decode u_dec (
      .addr      (dec_addr[g]),
      .cfg       (cfg),
      .populated (dec_pop[g])
    );
  end

  regblk_select #(.AW(REG_AW), .PW(PER_W)) u_sel (
    .clk        (clk),
    .rst        (rst),
    .sel_stb    (sel_stb),
    .per_stb    (per_stb),
    .sel_value  (sel_value),
    .sel_pop    (dec_pop[0]),
    .sel_q      (sel_q),
    .active_q   (ram_active),
    .per_q      (per_addr),
    .conflict_q (conflict)
  );

  assign acc_ok = ram_active & dec_pop[1];

  regblk_store #(.DW(DATA_W), .AW(REG_AW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (acc_en & acc_we & acc_ok),
    .rd_en   (acc_en & ~acc_we),
    .rd_ok   (acc_ok),
    .addr    (acc_addr),
    .wr_data (acc_wdata),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/regblk_ram_chk.sv
module regblk_ram_chk #(
  parameter int DATA_W = 56
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_stb,
  input logic              per_stb,
  input logic [9:0]        sel_value,
  input logic              acc_en,
  input logic              acc_we,
  input logic [DATA_W-1:0] rd_data,
  input logic              ram_active,
  input logic              conflict
);
  // R8: selecting 010 leaves RAM inactive
  p_desel_010_r8: assert property (@(posedge clk) disable iff (rst)
    sel_stb && sel_value == 10'h010 |=> !ram_active);

  // R8: selecting 3F0-3FF leaves RAM inactive
  p_desel_top_r8: assert property (@(posedge clk) disable iff (rst)
    sel_stb && sel_value[9:4] == 6'h3F |=> !ram_active);

  // R4: status block always populated
  p_status_pop_r4: assert property (@(posedge clk) disable iff (rst)
    sel_stb && sel_value[9:4] == 6'h00 |=> ram_active);

  // R8: activity changes only on a select
  p_active_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !sel_stb |=> $stable(ram_active));

  // R9: a read while deselected returns zero
  p_idle_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    acc_en && !acc_we && !ram_active |=> rd_data == '0);

  // R11: peripheral strobe with RAM active sets the flag
  p_conflict_set_r11: assert property (@(posedge clk) disable iff (rst)
    per_stb && !sel_stb && ram_active |=> conflict);

  // R11: flag is sticky
  p_conflict_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    conflict |=> conflict);

  // R11: combined deselect and peripheral select raises no flag
  p_combined_clean_r11: assert property (@(posedge clk) disable iff (rst)
    sel_stb && per_stb && sel_value[9:4] == 6'h3F && !conflict |=> !conflict);
endmodule

bind regblk_ram regblk_ram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sel_stb    (sel_stb),
  .per_stb    (per_stb),
  .sel_value  (sel_value),
  .acc_en     (acc_en),
  .acc_we     (acc_we),
  .rd_data    (rd_data),
  .ram_active (ram_active),
  .conflict   (conflict)
);

// File: tb/regblk_ram_test.sv
module regblk_ram_test;
  localparam int DW = 56;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          sel_stb = 1'b0, per_stb = 1'b0;
  logic [9:0]    sel_value = '0;
  logic          cfg_xfunc = 1'b0, cfg_xmem_lo = 1'b0, cfg_xmem_hi = 1'b0;
  logic [2:0]    cfg_mod_count = '0;
  logic          acc_en = 1'b0, acc_we = 1'b0, acc_indexed = 1'b0;
  logic [3:0]    acc_idx = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic [DW-1:0] rd_data;
  logic          ram_active, conflict;
  logic [7:0]    per_addr;

  regblk_ram uut (.*);

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] mdl [1024];
  bit            known [1024];
  logic [9:0]    m_sel;
  bit            m_act, m_err;

  function automatic bit exp_pop(int a);
    int mods;
    mods = (cfg_mod_count > 4) ? 4 : int'(cfg_mod_count);
    if (a < 'h010) return 1;
    if (a >= 'h0C0 && a < 'h100) return 1;
    if (a >= 'h040 && a < 'h0C0) return cfg_xfunc;
    if (a >= 'h100 && a < 'h200) return ((a - 'h100) / 64) < mods;
    if (a > 'h200 && a < 'h2F0) return cfg_xmem_lo;
    if (a > 'h300 && a < 'h3F0) return cfg_xmem_hi;
    return 0;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    m_sel = 10'h010; m_act = 0; m_err = 0;
  endtask

  task automatic do_sel(logic [9:0] v, string req);
    @(negedge clk); sel_stb = 1'b1; sel_value = v;
    @(negedge clk); sel_stb = 1'b0;
    m_sel = v; m_act = exp_pop(int'(v));
    chk(req, 64'(ram_active), 64'(m_act));
  endtask

  task automatic do_per(logic [9:0] v, bit with_sel);
    bit pend;
    @(negedge clk); per_stb = 1'b1; sel_stb = with_sel; sel_value = v;
    @(negedge clk); per_stb = 1'b0; sel_stb = 1'b0;
    if (with_sel) begin m_sel = v; m_act = exp_pop(int'(v)); end
    pend = m_act;
    if (pend) m_err = 1;
    chk("R11 per_addr", 64'(per_addr), 64'(v[7:0]));
    chk("R11 conflict", 64'(conflict), 64'(m_err));
    if (with_sel) chk("R8 combined select", 64'(ram_active), 64'(m_act));
  endtask

  task automatic do_acc(bit idxd, bit we, logic [3:0] idx, logic [DW-1:0] d, string req);
    logic [9:0] a;
    bit ok;
    a  = idxd ? {m_sel[9:4], idx} : m_sel;
    ok = m_act && exp_pop(int'(a));
    @(negedge clk);
    acc_en = 1'b1; acc_we = we; acc_indexed = idxd; acc_idx = idx; acc_wdata = d;
    @(negedge clk); acc_en = 1'b0; acc_we = 1'b0;
    if (we) begin
      if (ok) begin mdl[a] = d; known[a] = 1; end
    end else if (!ok) chk(req, 64'(rd_data), 64'd0);
    else if (known[a]) chk(req, 64'(rd_data), 64'(mdl[a]));
  endtask

  function automatic logic [DW-1:0] rnd_word();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[DW-1:0];
  endfunction

  function automatic logic [9:0] pick_addr();
    logic [9:0] bases [12] = '{10'h000, 10'h0C0, 10'h040, 10'h0B0, 10'h100, 10'h140,
                               10'h180, 10'h1C0, 10'h200, 10'h2F0, 10'h300, 10'h3F0};
    if ($urandom_range(0, 3) == 0) return 10'($urandom_range(0, 1023));
    return bases[$urandom_range(0, 11)] | 10'($urandom_range(0, 15));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] va, vb;
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) known[i] = 0;
    do_reset();
    @(negedge clk);
    chk("R12 reset ram_active", 64'(ram_active), 64'd0);
    chk("R12 reset conflict", 64'(conflict), 64'd0);
    chk("R12 reset per_addr", 64'(per_addr), 64'd0);
    chk("R12 reset rd_data", 64'(rd_data), 64'd0);

    cfg_xfunc = 1; cfg_mod_count = 3'd2; cfg_xmem_lo = 1; cfg_xmem_hi = 0;

    // R1 R2: exact write then read back
    va = 56'h12_3456_789A_BCDE;
    do_sel(10'h005, "R1 select 005");
    do_acc(0, 1, 4'd0, va, "R2 write");
    do_acc(0, 0, 4'd0, '0, "R2 exact read");
    chk("R2 exact read value", 64'(rd_data), 64'(va));

    // R3: indexed fill of block 0C0, read from another selection in it
    for (int k = 0; k < 16; k++) begin
      do_sel(10'h0C0 | 10'(k), "R1 select in 0C0");
      do_acc(0, 1, 4'd0, 56'(k * 56'h1_0101 + 7), "R2 fill");
    end
    do_sel(10'h0CA, "R1 select 0CA");
    do_acc(1, 0, 4'd3, '0, "R3 indexed read");
    chk("R3 indexed value", 64'(rd_data), 64'(3 * 56'h1_0101 + 7));
    do_acc(1, 1, 4'd15, 56'hAB, "R3 indexed write");
    do_sel(10'h0CF, "R1 select 0CF");
    do_acc(0, 0, 4'd0, '0, "R3 indexed write landed");
    chk("R3 exact sees indexed write", 64'(rd_data), 64'hAB);

    // R4-R8: map edges
    do_sel(10'h010, "R8 select 010");
    do_sel(10'h03F, "R4 03F");
    do_sel(10'h040, "R5 040");
    do_sel(10'h0BF, "R5 0BF");
    do_sel(10'h0C0, "R4 0C0");
    do_sel(10'h17F, "R6 17F");
    do_sel(10'h180, "R6 180");
    do_sel(10'h200, "R4 200");
    do_sel(10'h201, "R7 201");
    do_sel(10'h2EF, "R7 2EF");
    do_sel(10'h2F0, "R4 2F0");
    do_sel(10'h300, "R4 300");
    do_sel(10'h301, "R7 301");
    do_sel(10'h3F0, "R8 3F0");
    do_sel(10'h3FF, "R8 3FF");
    cfg_xfunc = 0;
    do_sel(10'h080, "R5 off");
    cfg_mod_count = 3'd7;
    do_sel(10'h1FF, "R6 clamp");
    cfg_mod_count = 3'd0;
    do_sel(10'h100, "R6 none");
    cfg_mod_count = 3'd2; cfg_xfunc = 1;

    // R9: writes while deselected are dropped
    do_sel(10'h010, "R9 deselect");
    do_acc(0, 1, 4'd0, 56'hDEAD, "R9 write ignored");
    do_acc(0, 0, 4'd0, '0, "R9 read zero");
    do_sel(10'h005, "R9 reselect");
    do_acc(0, 0, 4'd0, '0, "R9 value kept");
    chk("R9 kept value", 64'(rd_data), 64'(va));

    // R10: hole at 200 within the 200 block
    do_sel(10'h201, "R10 select 201");
    do_acc(1, 1, 4'd0, 56'h77, "R10 write hole");
    do_acc(1, 0, 4'd0, '0, "R10 read hole");
    chk("R10 hole reads zero", 64'(rd_data), 64'd0);
    vb = 56'h5A5A;
    do_acc(1, 1, 4'd1, vb, "R10 neighbour write");
    do_acc(1, 0, 4'd1, '0, "R10 neighbour read");
    chk("R10 neighbour value", 64'(rd_data), 64'(vb));

    // R11: conflict, then reset clears it but memory stays (R12)
    do_sel(10'h005, "R11 select");
    do_per(10'h0FD, 0);
    do_per(10'h010, 0);
    do_reset();
    @(negedge clk);
    chk("R12 conflict cleared", 64'(conflict), 64'd0);
    chk("R12 deselected", 64'(ram_active), 64'd0);
    do_acc(0, 0, 4'd0, '0, "R12 read while reset-deselected");
    do_sel(10'h005, "R12 reselect");
    do_acc(0, 0, 4'd0, '0, "R12 contents kept");
    chk("R12 contents kept value", 64'(rd_data), 64'(va));
    do_per(10'h3FD, 1);
    chk("R11 combined no conflict", 64'(conflict), 64'd0);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom_range(0, 19);
      if (k == 0) begin
        cfg_xfunc = 1'($urandom()); cfg_mod_count = 3'($urandom());
        cfg_xmem_lo = 1'($urandom()); cfg_xmem_hi = 1'($urandom());
      end else if (k < 6) do_sel(pick_addr(), "R8 random select");
      else if (k == 6) do_per(pick_addr(), 1'($urandom()));
      else do_acc(1'($urandom()), 1'($urandom()), 4'($urandom()), rnd_word(), "R3 random access");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule